// File: doc/BRIEF.md
# Coprocessor Conditional Instruction Sequencer

This block runs the processor-side part of three coprocessor-conditional instruction forms. The forms are set-byte-on-condition, loop-decrement-and-branch-on-condition and trap-on-condition. An instruction is issued with a 3-bit mode field, a 3-bit register field and the address of its opcode.

The block first pulls the command word from an instruction-word stream. It then pulls any operand words the form carries: a branch displacement, or one or two immediate words. The low six bits of the command word are presented to a coprocessor as the condition predicate. The block holds that request until the coprocessor answers with a true/false reply.

With the reply in hand, the block does one of four things:
- updates its eight-entry data register file;
- issues a byte write request for a memory operand;
- raises a coprocessor trap;
- raises an emulation trap for a reserved code.

In every case it reports the next program counter with a one-cycle completion pulse.

Top module: `cp_cond_seq`

## Requirements
- R1: Mode 111 with register field 000, 001, 101, 110 or 111 is reserved. Issuing it produces, on the next cycle, a completion pulse with the emulation trap set and next PC equal to the opcode address. No word is consumed and no coprocessor request is made.
- R2: Every non-reserved form consumes the command word. It then raises the coprocessor request with the predicate equal to command word bits [5:0], and holds both request and predicate steady until the reply strobe arrives.
- R3: Set form with mode 000 writes 0xFF (true) or 0x00 (false) into bits [7:0] of the named register. Bits [31:8] are left unchanged. No memory write is requested.
- R4: Set form with modes 010 to 110 leaves the register file unchanged. It issues a one-cycle memory write request carrying the mode, the register field and the byte 0xFF or 0x00.
- R5: Every set form consumes exactly one word (the command word), and its next PC is the opcode address + 4.
- R6: Loop form (mode 001) with a true reply leaves the counter register unchanged. Its next PC is the opcode address + 6.
- R7: Loop form with a false reply decrements bits [15:0] of the named register, wrapping 0x0000 to 0xFFFF. Bits [31:16] are left unchanged.
- R8: Loop form, false reply, new low word not 0xFFFF: next PC is (opcode address + 4) plus the sign-extended 16-bit displacement, which is the second extension word.
- R9: Loop form, false reply, new low word equal to 0xFFFF: next PC is the opcode address + 6.
- R10: Trap forms are mode 111 with field 010 (one operand word), 011 (two operand words) and 100 (no operand). They consume the command word plus their operand words, and report next PC = opcode address + 4 + 2 × operand words. A true reply sets the coprocessor trap flag; a false reply does not.
- R11: The completion pulse lasts one cycle and busy is low in the cycle after it. After reset, busy, done, the word-ready signal and the coprocessor request are all low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe, taken while not busy |
| mode | input | 3 | Instruction mode field |
| regSel | input | 3 | Instruction register field |
| pcIn | input | 32 | Address of the opcode word |
| wordValid | input | 1 | Instruction stream word available |
| wordData | input | 16 | Instruction stream word |
| wordReady | output | 1 | Block takes the stream word this cycle |
| cpReq | output | 1 | Predicate request to the coprocessor |
| cpPred | output | 6 | Condition predicate |
| cpAck | input | 1 | Coprocessor reply strobe |
| cpTrue | input | 1 | Coprocessor reply value |
| regLoad | input | 1 | Register file load strobe |
| regLoadSel | input | 3 | Register to load |
| regLoadData | input | 32 | Load value |
| rdSel | input | 3 | Register read select |
| rdData | output | 32 | Register read value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| nextPc | output | 32 | Next program counter, valid at done |
| condTrue | output | 1 | Reply used, valid at done |
| trapCp | output | 1 | Coprocessor trap, with done |
| trapEmul | output | 1 | Emulation trap, with done |
| memWr | output | 1 | Memory byte write request, with done |
| memWrMode | output | 3 | Mode of the memory operand |
| memWrReg | output | 3 | Register field of the memory operand |
| memWrData | output | 8 | Byte to write |

## Verification
The bench aims at the loop counter's edges. A counter starting at 0x0000 must wrap to 0xFFFF and fall through; a design that compared against zero, or that let the borrow reach bit 16, would branch or corrupt the upper half. A negative displacement probes sign extension, and a wrong base address (the opcode instead of the displacement word) shows up as a next PC off by four. All three operand lengths of the trap form are run, so a miscounted operand skip gives a wrong next PC and a wrong number of consumed stream words. Every reserved code is checked for consuming nothing and making no coprocessor request.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int NUM_REGS = 8;

  typedef enum logic [1:0] {K_SET, K_LOOP, K_TRAP, K_RSVD} opKind_t;

  typedef struct packed {
    logic    accept;
    logic    emul;
    logic    capCmd;
    logic    capOpnd;
    logic    cpDone;
    logic    exec;
    opKind_t kind;
  } ctrlStrobe_t;

  function automatic opKind_t kindOf(input logic [2:0] mode, input logic [2:0] sel);
    opKind_t k;
    if (mode == 3'b001) k = K_LOOP;
    else if (mode != 3'b111) k = K_SET;
    else begin
      case (sel)
        3'b010, 3'b011, 3'b100: k = K_TRAP;
        default:                k = K_RSVD;
      endcase
    end
    return k;
  endfunction

  function automatic logic [1:0] opndWordsOf(input logic [2:0] mode, input logic [2:0] sel);
    logic [1:0] n;
    n = 2'd0;
    if (mode == 3'b001) n = 2'd1;
    else if (mode == 3'b111) begin
      case (sel)
        3'b010:  n = 2'd1;
        3'b011:  n = 2'd2;
        default: n = 2'd0;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  mode,
  input  logic [2:0]  regSel,
  input  logic        wordValid,
  input  logic        cpAck,
  output logic        wordReady,
  output logic        cpReq,
  output logic        busy,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_OPND, S_CP, S_EXEC} state_t;

  state_t     state;
  opKind_t    kindQ;
  logic [1:0] leftQ;
  opKind_t    startKind;

  assign startKind = kindOf(mode, regSel);
  assign wordReady = (state == S_CMD) || (state == S_OPND);
  assign cpReq     = (state == S_CP);
  assign busy      = (state != S_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.kind    = (state == S_IDLE) ? startKind : kindQ;
    strobe.accept  = (state == S_IDLE) && start && (startKind != K_RSVD);
    strobe.emul    = (state == S_IDLE) && start && (startKind == K_RSVD);
    strobe.capCmd  = (state == S_CMD) && wordValid;
    strobe.capOpnd = (state == S_OPND) && wordValid;
    strobe.cpDone  = (state == S_CP) && cpAck;
    strobe.exec    = (state == S_EXEC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_SET;
      leftQ <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (strobe.accept) begin
          state <= S_CMD;
          kindQ <= startKind;
          leftQ <= opndWordsOf(mode, regSel);
        end
        S_CMD: if (wordValid) state <= (leftQ != 2'd0) ? S_OPND : S_CP;
        S_OPND: if (wordValid) begin
          leftQ <= leftQ - 2'd1;
          if (leftQ == 2'd1) state <= S_CP;
        end
        S_CP:   if (cpAck) state <= S_EXEC;
        S_EXEC: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccs_datapath.sv
module ccs_datapath
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int PRED_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        mode,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [15:0]       wordData,
  input  logic              cpTrue,
  input  logic              regLoad,
  input  logic [2:0]        regLoadSel,
  input  logic [REG_W-1:0]  regLoadData,
  input  logic [2:0]        rdSel,
  output logic [REG_W-1:0]  rdData,
  output logic [PRED_W-1:0] cpPred,
  output logic [ADDR_W-1:0] nextPc,
  output logic              done,
  output logic              condTrue,
  output logic              trapCp,
  output logic              trapEmul,
  output logic              memWr,
  output logic [2:0]        memWrMode,
  output logic [2:0]        memWrReg,
  output logic [7:0]        memWrData
);

  localparam int SEXT_W = ADDR_W - 16;
  localparam logic [15:0] CNT_END = '1;

  logic [REG_W-1:0]  regFile [NUM_REGS];
  logic [ADDR_W-1:0] pcQ;
  logic [2:0]        modeQ, selQ;
  logic [15:0]       dispQ;
  logic [1:0]        opndCnt;
  logic              condQ;
  logic [PRED_W-1:0] predQ;

  logic [ADDR_W-1:0] fallPc, branchPc;
  logic [15:0]       decCnt;
  logic              rfWe;
  logic [REG_W-1:0]  rfWdata;
  logic [7:0]        setByte;

  assign fallPc   = pcQ + ADDR_W'(4) + ADDR_W'({opndCnt, 1'b0});
  assign branchPc = pcQ + ADDR_W'(4) + {{SEXT_W{dispQ[15]}}, dispQ};
  assign decCnt   = regFile[selQ][15:0] - 16'd1;
  assign setByte  = condQ ? 8'hFF : 8'h00;
  assign rdData   = regFile[rdSel];
  assign cpPred   = predQ;

  always_comb begin
    rfWe    = 1'b0;
    rfWdata = regFile[selQ];
    if (strobe.exec) begin
      if (strobe.kind == K_SET && modeQ == 3'b000) begin
        rfWe         = 1'b1;
        rfWdata[7:0] = setByte;
      end else if (strobe.kind == K_LOOP && !condQ) begin
        rfWe          = 1'b1;
        rfWdata[15:0] = decCnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (regLoad) regFile[regLoadSel] <= regLoadData;
      if (rfWe) regFile[selQ] <= rfWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0; modeQ <= '0; selQ <= '0; dispQ <= '0; opndCnt <= '0;
      condQ <= 1'b0; predQ <= '0; nextPc <= '0; done <= 1'b0; condTrue <= 1'b0;
      trapCp <= 1'b0; trapEmul <= 1'b0; memWr <= 1'b0;
      memWrMode <= '0; memWrReg <= '0; memWrData <= '0;
    end else begin
      done     <= 1'b0;
      trapCp   <= 1'b0;
      trapEmul <= 1'b0;
      memWr    <= 1'b0;
      if (strobe.emul) begin
        nextPc   <= pcIn;
        trapEmul <= 1'b1;
        condTrue <= 1'b0;
        done     <= 1'b1;
      end
      if (strobe.accept) begin
        pcQ     <= pcIn;
        modeQ   <= mode;
        selQ    <= regSel;
        opndCnt <= 2'd0;
      end
      if (strobe.capCmd) predQ <= wordData[PRED_W-1:0];
      if (strobe.capOpnd) begin
        if (opndCnt == 2'd0) dispQ <= wordData;
        opndCnt <= opndCnt + 2'd1;
      end
      if (strobe.cpDone) condQ <= cpTrue;
      if (strobe.exec) begin
        done     <= 1'b1;
        condTrue <= condQ;
        nextPc   <= fallPc;
        case (strobe.kind)
          K_SET: if (modeQ != 3'b000) begin
            memWr     <= 1'b1;
            memWrMode <= modeQ;
            memWrReg  <= selQ;
            memWrData <= setByte;
          end
          K_LOOP: if (!condQ && decCnt != CNT_END) nextPc <= branchPc;
          K_TRAP: trapCp <= condQ;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cp_cond_seq.sv
module cp_cond_seq
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int PRED_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              wordValid,
  input  logic [15:0]       wordData,
  output logic              wordReady,
  output logic              cpReq,
  output logic [PRED_W-1:0] cpPred,
  input  logic              cpAck,
  input  logic              cpTrue,
  input  logic              regLoad,
  input  logic [2:0]        regLoadSel,
  input  logic [REG_W-1:0]  regLoadData,
  input  logic [2:0]        rdSel,
  output logic [REG_W-1:0]  rdData,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] nextPc,
  output logic              condTrue,
  output logic              trapCp,
  output logic              trapEmul,
  output logic              memWr,
  output logic [2:0]        memWrMode,
  output logic [2:0]        memWrReg,
  output logic [7:0]        memWrData
);

  ctrlStrobe_t strobe;

  ccs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .regSel(regSel),
    .wordValid(wordValid), .cpAck(cpAck), .wordReady(wordReady),
    .cpReq(cpReq), .busy(busy), .strobe(strobe)
  );

  ccs_datapath #(.ADDR_W(ADDR_W), .REG_W(REG_W), .PRED_W(PRED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .regSel(regSel),
    .pcIn(pcIn), .wordData(wordData), .cpTrue(cpTrue), .regLoad(regLoad),
    .regLoadSel(regLoadSel), .regLoadData(regLoadData), .rdSel(rdSel),
    .rdData(rdData), .cpPred(cpPred), .nextPc(nextPc), .done(done),
    .condTrue(condTrue), .trapCp(trapCp), .trapEmul(trapEmul), .memWr(memWr),
    .memWrMode(memWrMode), .memWrReg(memWrReg), .memWrData(memWrData)
  );

endmodule

// File: rtl/cp_cond_seq_chk.sv
module cp_cond_seq_chk #(
  parameter int PRED_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        mode,
  input logic [2:0]        regSel,
  input logic              busy,
  input logic              wordReady,
  input logic              cpReq,
  input logic              cpAck,
  input logic [PRED_W-1:0] cpPred,
  input logic              done,
  input logic              trapCp,
  input logic              trapEmul,
  input logic              memWr,
  input logic [7:0]        memWrData
);

  logic rsvdIssue;
  assign rsvdIssue = start && !busy && mode == 3'b111 &&
                     !(regSel == 3'b010 || regSel == 3'b011 || regSel == 3'b100);

  // R1
  rsvd_emul_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsvdIssue |=> (done && trapEmul && !busy && !cpReq));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpReq && !cpAck) |=> (cpReq && $stable(cpPred)));

  // R2
  req_no_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpReq |-> !wordReady);

  // R4
  mem_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (done && (memWrData == 8'hFF || memWrData == 8'h00)));

  // R10
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapCp |-> (done && !trapEmul && !memWr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind cp_cond_seq cp_cond_seq_chk #(.PRED_W(PRED_W)) u_chk (.*);

// File: tb/tb_cp_cond_seq.sv
module tb_cp_cond_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0, regSel = '0;
  logic [31:0] pcIn = '0;
  logic        wordValid = 1'b1;
  logic [15:0] wordData;
  logic        wordReady, cpReq;
  logic [5:0]  cpPred;
  logic        cpAck = 1'b0, cpTrue = 1'b0;
  logic        regLoad = 1'b0;
  logic [2:0]  regLoadSel = '0;
  logic [31:0] regLoadData = '0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        busy, done, condTrue, trapCp, trapEmul, memWr;
  logic [31:0] nextPc;
  logic [2:0]  memWrMode, memWrReg;
  logic [7:0]  memWrData;

  always #4 clk = ~clk;

  cp_cond_seq dut (.*);

  typedef struct {
    logic [31:0] pc;
    logic [31:0] regVal;
    logic        trapC, trapE, memW;
    logic [7:0]  memD;
    int          words, cps;
    logic [5:0]  pred;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          errors = 0, checks = 0;
  logic [15:0] streamMem [256];
  logic [7:0]  idx = '0;
  logic [7:0]  baseIdx = '0;
  int          cpCount = 0, baseCp = 0, cpWait = 0, cpLat = 0;
  logic        cpAns = 1'b0;
  logic [5:0]  seenPred = '0;
  logic [31:0] shadow [8];

  assign wordData = streamMem[idx];

  always @(posedge clk) if (wordReady && wordValid) idx <= idx + 8'd1;

  always @(posedge clk) begin
    cpAck <= 1'b0;
    if (!cpReq) cpWait <= 0;
    else if (!cpAck) begin
      if (cpWait >= cpLat) begin
        cpAck    <= 1'b1;
        cpTrue   <= cpAns;
        seenPred <= cpPred;
        cpCount  <= cpCount + 1;
        cpWait   <= 0;
      end else cpWait <= cpWait + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk(nextPc == e.pc, e.tag, "nextPc", nextPc, e.pc);
        chk(trapCp == e.trapC, e.tag, "trapCp", 32'(trapCp), 32'(e.trapC));
        chk(trapEmul == e.trapE, e.tag, "trapEmul", 32'(trapEmul), 32'(e.trapE));
        chk(memWr == e.memW, e.tag, "memWr", 32'(memWr), 32'(e.memW));
        if (e.memW) chk(memWrData == e.memD, e.tag, "memWrData", 32'(memWrData), 32'(e.memD));
        chk(rdData == e.regVal, e.tag, "register", rdData, e.regVal);
        chk(32'(idx - baseIdx) == 32'(e.words), e.tag, "words consumed",
            32'(idx - baseIdx), 32'(e.words));
        chk(cpCount - baseCp == e.cps, e.tag, "coprocessor requests",
            32'(cpCount - baseCp), 32'(e.cps));
        if (e.cps != 0) chk(seenPred == e.pred, "R2", "predicate", 32'(seenPred), 32'(e.pred));
      end
    end
  end

  task automatic loadReg(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    regLoad = 1'b1; regLoadSel = s; regLoadData = v;
    @(negedge clk);
    regLoad = 1'b0;
    shadow[s] = v;
  endtask

  // driver: computes the expected outcome from the requirements and issues
  task automatic runOp(input logic [2:0] m, input logic [2:0] s, input logic [31:0] pc,
                       input logic [15:0] cmd, input logic [15:0] op0, input logic [15:0] op1,
                       input bit ans, input int lat, input string tag);
    exp_t e;
    bit rsvd;
    int nw;
    logic [15:0] newc;
    logic [31:0] fall;
    @(negedge clk);
    streamMem[idx] = cmd;
    streamMem[idx + 8'd1] = op0;
    streamMem[idx + 8'd2] = op1;
    rsvd = (m == 3'b111) && !(s == 3'b010 || s == 3'b011 || s == 3'b100);
    nw = (m == 3'b001) ? 1 : (m == 3'b111) ? ((s == 3'b010) ? 1 : (s == 3'b011) ? 2 : 0) : 0;
    e.tag = tag; e.trapC = 0; e.trapE = 0; e.memW = 0; e.memD = 0;
    e.pred = cmd[5:0];
    if (rsvd) begin
      e.pc = pc; e.trapE = 1; e.words = 0; e.cps = 0;
    end else begin
      e.words = 1 + nw; e.cps = 1;
      fall = pc + 32'd4 + 32'(2 * nw);
      e.pc = fall;
      if (m == 3'b001) begin
        if (!ans) begin
          newc = shadow[s][15:0] - 16'd1;
          shadow[s][15:0] = newc;
          if (newc != 16'hFFFF) e.pc = pc + 32'd4 + {{16{op0[15]}}, op0};
        end
      end else if (m == 3'b111) e.trapC = ans;
      else if (m == 3'b000) shadow[s][7:0] = ans ? 8'hFF : 8'h00;
      else begin
        e.memW = 1; e.memD = ans ? 8'hFF : 8'h00;
      end
    end
    e.regVal = shadow[s];
    expQ.push_back(e);
    cpAns = ans; cpLat = lat; rdSel = s;
    baseIdx = idx; baseCp = cpCount;
    mode = m; regSel = s; pcIn = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R11", "done pulse width / busy after done",
        32'({done, busy}), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) streamMem[i] = 16'h0;
    for (int i = 0; i < 8; i++) shadow[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wordReady && !cpReq, "R11", "reset outputs",
        32'({busy, done, wordReady, cpReq}), 32'd0);
    rdSel = 3'd6;
    #1 chk(rdData == 32'h0, "R11", "reset register", rdData, 32'h0);

    loadReg(3'd3, 32'h1234_5600);
    loadReg(3'd5, 32'hAAAA_55FF);
    loadReg(3'd2, 32'hCAFE_0042);
    loadReg(3'd1, 32'h0001_0005);
    loadReg(3'd4, 32'h7777_0000);
    loadReg(3'd7, 32'h0000_0003);

    runOp(3'b000, 3'd3, 32'h0000_1000, 16'h0015, 16'h0, 16'h0, 1'b1, 0, "R3");
    runOp(3'b000, 3'd5, 32'h0000_2000, 16'h002A, 16'h0, 16'h0, 1'b0, 2, "R3");
    runOp(3'b101, 3'd2, 32'h0000_2100, 16'h0003, 16'h0, 16'h0, 1'b1, 1, "R4");
    runOp(3'b010, 3'd2, 32'h0000_2200, 16'h003F, 16'h0, 16'h0, 1'b0, 0, "R5");
    runOp(3'b001, 3'd1, 32'h0000_3000, 16'h0011, 16'hFFF0, 16'h0, 1'b1, 1, "R6");
    runOp(3'b001, 3'd1, 32'h0000_3000, 16'h0011, 16'hFFF0, 16'h0, 1'b0, 3, "R8");
    runOp(3'b001, 3'd4, 32'h0000_4000, 16'h0012, 16'h0100, 16'h0, 1'b0, 0, "R7");
    runOp(3'b001, 3'd7, 32'h0000_5000, 16'h0013, 16'h0100, 16'h0, 1'b0, 1, "R8");
    loadReg(3'd7, 32'h0000_0000);
    runOp(3'b001, 3'd7, 32'h0000_5800, 16'h0014, 16'h0100, 16'h0, 1'b0, 0, "R9");
    runOp(3'b111, 3'b010, 32'h0000_6000, 16'h0021, 16'h1111, 16'h0, 1'b1, 2, "R10");
    runOp(3'b111, 3'b011, 32'h0000_6100, 16'h0022, 16'h2222, 16'h3333, 1'b0, 1, "R10");
    runOp(3'b111, 3'b100, 32'h0000_6200, 16'h0023, 16'h0, 16'h0, 1'b1, 0, "R10");
    runOp(3'b111, 3'b000, 32'h0000_7000, 16'h0001, 16'h0, 16'h0, 1'b1, 0, "R1");
    runOp(3'b111, 3'b001, 32'h0000_7100, 16'h0001, 16'h0, 16'h0, 1'b1, 0, "R1");
    runOp(3'b111, 3'b101, 32'h0000_7200, 16'h0001, 16'h0, 16'h0, 1'b1, 0, "R1");
    runOp(3'b111, 3'b110, 32'h0000_7300, 16'h0001, 16'h0, 16'h0, 1'b0, 0, "R1");
    runOp(3'b111, 3'b111, 32'h0000_7400, 16'h0001, 16'h0, 16'h0, 1'b1, 0, "R1");
    runOp(3'b011, 3'd6, 32'h0000_8000, 16'h0007, 16'h0, 16'h0, 1'b1, 4, "R2");

    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R11", "scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule